// File: doc/BRIEF.md
# Two-Level Maskable Interrupt Aggregator

This block gathers event pulses from a packet-processing engine into one level-sensitive interrupt line. There are three top-level sources: two microcontroller events and a transmit-suspend summary. Each source has its own bit in a raw status register, an enable register and a write-one-to-clear register. Software can therefore mask and acknowledge each source on its own. The raw status records an event whether or not it is enabled. The output line is high while any bit is both pending and enabled.

The transmit-suspend source sits on a second level. Per-endpoint suspend pulses are collected in banked 32-bit info registers. Endpoint n lives in bank n/32 at bit n%32. Every bank has its own clear register and per-endpoint enable register. Any accepted endpoint pulse raises the summary bit. Acknowledging the summary bit at the top level also wipes every bank's info register.

A legacy parameter selects the older behaviour. In that mode the info registers can never be cleared, the per-endpoint enables are absent and every endpoint pulse is accepted. Software reaches all registers through a simple synchronous port: a write takes effect at the clock edge, and the read data follow the address combinationally.

Top module: `evt_irq_agg`

## Requirements
- R1: Word 0 is the enable register. Bits 2:0 are read/write, bit 0 and bit 1 are the microcontroller sources and bit 2 is transmit-suspend. Bits 31:3 read 0.
- R2: Word 1 is the raw status register, with the same bit assignment as R1. A pulse on a microcontroller source sets its bit at the next edge whatever the enable holds. Bits 31:3 read 0.
- R3: `irq_o` is high exactly while the registered status AND enable is nonzero.
- R4: Word 2 is the top-level clear register. Writing 1 to a bit clears that status bit, writing 0 leaves it unchanged, and the register reads 0.
- R5: Endpoint n maps to bank n/32, bit n%32. Bank u's info register is at word 3+u. A pulse whose suspend-enable bit is 1 sets the info bit and status bit 2. Bits for endpoints that do not exist read 0.
- R6: Bank u's suspend-enable register is at word 3+2U+u, where U is the bank count (the endpoint count divided by 32, rounded up). It is read/write for existing endpoints only.
- R7: Bank u's clear register is at word 3+U+u. It is write-one-to-clear on the info bits and reads 0.
- R8: Writing 1 to bit 2 of the top-level clear register also clears every info register.
- R9: When an event and a clear hit the same bit in the same cycle, the bit ends up set. This holds at both levels.
- R10: In legacy mode, info bits are never cleared, by either the bank clear or the top-level wipe. Writes to the suspend-enable registers are ignored and those registers read 0. Every endpoint pulse is accepted.
- R11: After reset, all enable, status and info registers read 0 and `irq_o` is low.
- R12: Reads of unmapped word offsets return 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mc_evt_i | input | 2 | Microcontroller event pulses, bit i is source i |
| ep_susp_i | input | NUM_EP | Per-endpoint suspend pulses |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | ADDR_W | Word offset for read and write |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i |
| irq_o | output | 1 | Level interrupt output |

## Verification
Two things can land on the same bit in one cycle: a new event and a software acknowledge. Directed steps provoke this for a microcontroller status bit, which gets a pulse and a clear on one edge. They also provoke it for an info bit, which gets an endpoint pulse while the top-level summary clear wipes the banks. The following read must show the bit still set. Random traffic produces further collisions. A reference model advanced with the same stimulus judges every cycle, for both a normal instance and a legacy instance.

// File: rtl/evt_irq_agg_pkg.sv
package evt_irq_agg_pkg;
    localparam int SRC_W    = 3;
    localparam int SRC_MC0  = 0;
    localparam int SRC_MC1  = 1;
    localparam int SRC_SUSP = 2;
    localparam int UNIT_W   = 32;

    localparam int OFF_EN   = 0;
    localparam int OFF_STS  = 1;
    localparam int OFF_CLR  = 2;
    localparam int OFF_BANK = 3;

    function automatic int unit_count(int n);
        return (n + UNIT_W - 1) / UNIT_W;
    endfunction

    function automatic int lanes_in_unit(int n, int u);
        int r;
        r = n - u * UNIT_W;
        return (r > UNIT_W) ? UNIT_W : r;
    endfunction

    function automatic logic [31:0] lane_mask(int lanes);
        logic [63:0] m;
        m = (64'd1 << lanes) - 64'd1;
        return m[31:0];
    endfunction

    typedef struct packed {
        logic [SRC_W-1:0] en;
        logic [SRC_W-1:0] sts;
    } top_state_t;

    typedef struct packed {
        logic [31:0] info;
        logic [31:0] en;
    } unit_state_t;
endpackage

// File: rtl/irq_susp_unit.sv
module irq_susp_unit
    import evt_irq_agg_pkg::*;
#(
    parameter int LANES  = 32,
    parameter bit LEGACY = 1'b0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] evt,
    input  logic        en_we,
    input  logic        clr_we,
    input  logic        wipe,
    input  logic [31:0] wdata,
    output logic [31:0] info,
    output logic [31:0] en,
    output logic        hit
);
    localparam logic [31:0] VALID = lane_mask(LANES);

    unit_state_t st_d, st_q;
    logic [31:0] accept;
    logic [31:0] clr_bits;

    always_comb begin
        // legacy mode accepts every existing lane
        accept   = evt & VALID & (LEGACY ? VALID : st_q.en);
        clr_bits = '0;
        if (!LEGACY) begin
            if (clr_we) clr_bits = wdata;
            if (wipe)   clr_bits = '1;
        end
        st_d      = st_q;
        // a fresh pulse overrides a same-cycle clear
        st_d.info = (st_q.info & ~clr_bits) | accept;
        if (en_we && !LEGACY) st_d.en = wdata & VALID;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign info = st_q.info;
    assign en   = st_q.en;
    assign hit  = |accept;
endmodule

// File: rtl/irq_top_level.sv
module irq_top_level
    import evt_irq_agg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mc_evt,
    input  logic             susp_hit,
    input  logic             en_we,
    input  logic             clr_we,
    input  logic [SRC_W-1:0] wdata,
    output logic [SRC_W-1:0] en,
    output logic [SRC_W-1:0] sts,
    output logic             wipe,
    output logic             irq
);
    top_state_t st_d, st_q;
    logic [SRC_W-1:0] set_bits;
    logic [SRC_W-1:0] clr_bits;

    always_comb begin
        set_bits           = '0;
        set_bits[SRC_MC0]  = mc_evt[0];
        set_bits[SRC_MC1]  = mc_evt[1];
        set_bits[SRC_SUSP] = susp_hit;
        clr_bits           = clr_we ? wdata : '0;
        st_d               = st_q;
        st_d.sts           = (st_q.sts & ~clr_bits) | set_bits;
        if (en_we) st_d.en = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en   = st_q.en;
    assign sts  = st_q.sts;
    assign wipe = clr_we & wdata[SRC_SUSP];
    assign irq  = |(st_q.sts & st_q.en);
endmodule

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
    import evt_irq_agg_pkg::*;
#(
    parameter int NUM_UNITS = 2,
    parameter int ADDR_W    = 6
) (
    input  logic                        we,
    input  logic [ADDR_W-1:0]           addr,
    input  logic [SRC_W-1:0]            top_en,
    input  logic [SRC_W-1:0]            top_sts,
    input  logic [NUM_UNITS*UNIT_W-1:0] info_all,
    input  logic [NUM_UNITS*UNIT_W-1:0] sen_all,
    output logic                        top_en_we,
    output logic                        top_clr_we,
    output logic [NUM_UNITS-1:0]        unit_clr_we,
    output logic [NUM_UNITS-1:0]        unit_en_we,
    output logic [31:0]                 rdata
);
    localparam int OFF_UCLR = OFF_BANK + NUM_UNITS;
    localparam int OFF_UEN  = OFF_BANK + 2 * NUM_UNITS;

    int a;

    always_comb begin
        a           = int'(addr);
        top_en_we   = 1'b0;
        top_clr_we  = 1'b0;
        unit_clr_we = '0;
        unit_en_we  = '0;
        rdata       = '0;
        if (a == OFF_EN) begin
            top_en_we = we;
            rdata     = 32'(top_en);
        end
        if (a == OFF_STS) rdata = 32'(top_sts);
        if (a == OFF_CLR) top_clr_we = we;
        for (int u = 0; u < NUM_UNITS; u++) begin
            if (a == OFF_BANK + u) rdata = info_all[u*UNIT_W +: UNIT_W];
            if (a == OFF_UCLR + u) unit_clr_we[u] = we;
            if (a == OFF_UEN + u) begin
                unit_en_we[u] = we;
                rdata         = sen_all[u*UNIT_W +: UNIT_W];
            end
        end
    end
endmodule

// File: rtl/evt_irq_agg.sv
module evt_irq_agg
    import evt_irq_agg_pkg::*;
#(
    parameter int NUM_EP = 40,
    parameter int ADDR_W = 6,
    parameter bit LEGACY = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mc_evt_i,
    input  logic [NUM_EP-1:0] ep_susp_i,
    input  logic              bus_we_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [31:0]       bus_wdata_i,
    output logic [31:0]       bus_rdata_o,
    output logic              irq_o
);
    localparam int NUM_UNITS = unit_count(NUM_EP);
    localparam int PAD_W     = NUM_UNITS * UNIT_W;

    logic [PAD_W-1:0]     ep_pad;
    logic [PAD_W-1:0]     info_all;
    logic [PAD_W-1:0]     sen_all;
    logic [NUM_UNITS-1:0] unit_hit;
    logic [NUM_UNITS-1:0] unit_clr_we;
    logic [NUM_UNITS-1:0] unit_en_we;
    logic [SRC_W-1:0]     top_en;
    logic [SRC_W-1:0]     top_sts;
    logic                 top_en_we;
    logic                 top_clr_we;
    logic                 wipe;
    logic                 susp_hit;

    assign ep_pad   = PAD_W'(ep_susp_i);
    assign susp_hit = |unit_hit;

    irq_reg_decode #(.NUM_UNITS(NUM_UNITS), .ADDR_W(ADDR_W)) u_dec (
        .we          (bus_we_i),
        .addr        (bus_addr_i),
        .top_en      (top_en),
        .top_sts     (top_sts),
        .info_all    (info_all),
        .sen_all     (sen_all),
        .top_en_we   (top_en_we),
        .top_clr_we  (top_clr_we),
        .unit_clr_we (unit_clr_we),
        .unit_en_we  (unit_en_we),
        .rdata       (bus_rdata_o)
    );

    irq_top_level u_top (
        .clk      (clk),
        .rst_n    (rst_n),
        .mc_evt   (mc_evt_i),
        .susp_hit (susp_hit),
        .en_we    (top_en_we),
        .clr_we   (top_clr_we),
        .wdata    (bus_wdata_i[SRC_W-1:0]),
        .en       (top_en),
        .sts      (top_sts),
        .wipe     (wipe),
        .irq      (irq_o)
    );

    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_bank
        irq_susp_unit #(
            .LANES  (lanes_in_unit(NUM_EP, u)),
            .LEGACY (LEGACY)
        ) u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .evt    (ep_pad[u*UNIT_W +: UNIT_W]),
            .en_we  (unit_en_we[u]),
            .clr_we (unit_clr_we[u]),
            .wipe   (wipe),
            .wdata  (bus_wdata_i),
            .info   (info_all[u*UNIT_W +: UNIT_W]),
            .en     (sen_all[u*UNIT_W +: UNIT_W]),
            .hit    (unit_hit[u])
        );
    end
endmodule

// File: rtl/irq_agg_chk.sv
module irq_agg_chk
    import evt_irq_agg_pkg::*;
#(
    parameter int NUM_UNITS = 2,
    parameter int ADDR_W    = 6,
    parameter bit LEGACY    = 1'b0
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [1:0]                  mc_evt_i,
    input logic                        bus_we_i,
    input logic [ADDR_W-1:0]           bus_addr_i,
    input logic [31:0]                 bus_wdata_i,
    input logic [31:0]                 bus_rdata_o,
    input logic                        irq_o,
    input logic [SRC_W-1:0]            sts,
    input logic [SRC_W-1:0]            en,
    input logic [NUM_UNITS*UNIT_W-1:0] info_all,
    input logic                        any_acc
);
    logic clr_wr;
    assign clr_wr = bus_we_i && (bus_addr_i == ADDR_W'(OFF_CLR));

    // R2
    mc0_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mc_evt_i[0] |=> sts[SRC_MC0]);

    // R4
    mc0_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && bus_wdata_i[SRC_MC0] && !mc_evt_i[0]) |=> !sts[SRC_MC0]);

    // R9
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && bus_wdata_i[SRC_MC1] && mc_evt_i[1]) |=> sts[SRC_MC1]);

    // R3
    irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en == '0) |-> !irq_o);

    // R2
    sts_rsv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr_i == ADDR_W'(OFF_STS)) |-> (bus_rdata_o[31:SRC_W] == '0));

    if (!LEGACY) begin : g_norm
        // R8
        wipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_wr && bus_wdata_i[SRC_SUSP] && !any_acc) |=> (info_all == '0));
    end else begin : g_leg
        // R10
        leg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> ((info_all & $past(info_all)) == $past(info_all)));
    end
endmodule

bind evt_irq_agg irq_agg_chk #(
    .NUM_UNITS (NUM_UNITS),
    .ADDR_W    (ADDR_W),
    .LEGACY    (LEGACY)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mc_evt_i    (mc_evt_i),
    .bus_we_i    (bus_we_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .bus_rdata_o (bus_rdata_o),
    .irq_o       (irq_o),
    .sts         (top_sts),
    .en          (top_en),
    .info_all    (info_all),
    .any_acc     (susp_hit)
);

// File: tb/evt_irq_agg_bench.sv
module evt_irq_agg_bench;
    localparam int NEP = 40;
    localparam int AW  = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mc = '0;
    logic [NEP-1:0] ep = '0;
    logic        we = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [31:0] wd = '0;
    logic [31:0] rd0, rd1;
    logic        irq0, irq1;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    logic [2:0]  m_en  [2];
    logic [2:0]  m_sts [2];
    logic [31:0] m_info[2][2];
    logic [31:0] m_sen [2][2];

    always #4 clk = ~clk;

    evt_irq_agg #(.NUM_EP(NEP), .ADDR_W(AW), .LEGACY(1'b0)) u_evt_irq_agg (
        .clk(clk), .rst_n(rst_n), .mc_evt_i(mc), .ep_susp_i(ep), .bus_we_i(we),
        .bus_addr_i(addr), .bus_wdata_i(wd), .bus_rdata_o(rd0), .irq_o(irq0));

    evt_irq_agg #(.NUM_EP(NEP), .ADDR_W(AW), .LEGACY(1'b1)) u_evt_irq_agg_leg (
        .clk(clk), .rst_n(rst_n), .mc_evt_i(mc), .ep_susp_i(ep), .bus_we_i(we),
        .bus_addr_i(addr), .bus_wdata_i(wd), .bus_rdata_o(rd1), .irq_o(irq1));

    function automatic logic [31:0] vmask(int u);
        return (u == 0) ? 32'hFFFF_FFFF : 32'h0000_00FF;
    endfunction

    function automatic logic [31:0] exp_rd(int k, int a);
        if (a == 0) return 32'(m_en[k]);
        if (a == 1) return 32'(m_sts[k]);
        if (a == 3 || a == 4) return m_info[k][a-3];
        if (a == 7 || a == 8) return m_sen[k][a-7];
        return 32'h0;
    endfunction

    function automatic string addr_tag(int a);
        if (a == 0) return "R1";
        if (a == 1) return "R2";
        if (a == 2) return "R4";
        if (a == 3 || a == 4) return "R5";
        if (a == 5 || a == 6) return "R7";
        if (a == 7 || a == 8) return "R6";
        return "R12";
    endfunction

    task automatic check(string tag, int k, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s inst=%0d addr=%0d actual=%h expected=%h", tag, k, addr, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int k = 0; k < 2; k++) begin
            m_en[k] = '0; m_sts[k] = '0;
            for (int u = 0; u < 2; u++) begin m_info[k][u] = '0; m_sen[k][u] = '0; end
        end
    endtask

    task automatic model_step(int k);
        logic [63:0] epp;
        logic [31:0] acc[2];
        logic [2:0]  clr;
        logic [31:0] c;
        bit leg;
        int a;
        leg = (k == 1);
        a   = int'(addr);
        epp = 64'(ep);
        for (int u = 0; u < 2; u++)
            acc[u] = epp[u*32 +: 32] & vmask(u) & (leg ? 32'hFFFF_FFFF : m_sen[k][u]);
        clr = (we && a == 2) ? wd[2:0] : 3'b0;
        m_sts[k] = (m_sts[k] & ~clr) | {(|acc[0]) | (|acc[1]), mc};
        if (we && a == 0) m_en[k] = wd[2:0];
        for (int u = 0; u < 2; u++) begin
            c = '0;
            if (!leg) begin
                if (we && a == 5 + u) c = wd;
                if (clr[2]) c = 32'hFFFF_FFFF;
            end
            m_info[k][u] = (m_info[k][u] & ~c) | acc[u];
            if (!leg && we && a == 7 + u) m_sen[k][u] = wd & vmask(u);
        end
    endtask

    // one bus cycle: drive, check the state seen before the edge, then advance the model
    task automatic cyc(logic [1:0] m, logic [NEP-1:0] e, logic w, int a, logic [31:0] d, string tag);
        string t;
        @(negedge clk);
        mc = m; ep = e; we = w; addr = AW'(a); wd = d;
        #1;
        t = (tag == "") ? addr_tag(a) : tag;
        check(t, 0, rd0, exp_rd(0, a));
        check((t == "R6" || t == "R7") ? "R10" : t, 1, rd1, exp_rd(1, a));
        check("R3", 0, 32'(irq0), 32'(|(m_sts[0] & m_en[0])));
        check("R3", 1, 32'(irq1), 32'(|(m_sts[1] & m_en[1])));
        @(posedge clk);
        model_step(0);
        model_step(1);
    endtask

    task automatic rd(int a, string tag);
        cyc(2'b0, '0, 1'b0, a, 32'h0, tag);
    endtask

    task automatic wr(int a, logic [31:0] d);
        cyc(2'b0, '0, 1'b1, a, d, "");
    endtask

    function automatic logic [NEP-1:0] ep_bit(int n);
        return NEP'(1) << n;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL R11 watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd715));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R11 reset state of every mapped word
        for (int a = 0; a < 9; a++) rd(a, "R11");

        // R1 only three writable bits
        wr(0, 32'hFFFF_FFFF); rd(0, "R1");
        wr(0, 32'h0);
        // R2 status set while masked, R3 line stays low
        cyc(2'b01, '0, 1'b0, 1, 32'h0, "R2"); rd(1, "R2");
        // R3 enabling raises the line
        wr(0, 32'h1); rd(1, "R3");
        // R4 zero write keeps, one write clears
        wr(2, 32'h0); rd(1, "R4");
        wr(2, 32'h1); rd(1, "R4");
        // R5 pulse while endpoint enable is 0: normal ignores, legacy records (R10)
        cyc(2'b0, ep_bit(10), 1'b0, 3, 32'h0, "R5"); rd(3, "R5"); rd(1, "R10");
        wr(2, 32'h4);
        // R6 enables, only existing endpoints stick
        wr(7, 32'hFFFF_FFFF); wr(8, 32'hFFFF_FFFF); rd(7, "R6"); rd(8, "R6");
        // R5 bank mapping of endpoints 5 and 33
        cyc(2'b0, ep_bit(5) | ep_bit(33), 1'b0, 3, 32'h0, "R5");
        rd(3, "R5"); rd(4, "R5"); rd(1, "R5");
        // R7 bank clear of bit 5, reads of clear words are 0
        wr(5, 32'h20); rd(3, "R7"); rd(5, "R7"); rd(6, "R7");
        // R9 microcontroller event against its own clear
        wr(0, 32'h7);
        cyc(2'b10, '0, 1'b1, 2, 32'h2, "R9"); rd(1, "R9");
        // R9 endpoint pulse against the summary wipe
        cyc(2'b0, ep_bit(34), 1'b1, 2, 32'h4, "R9"); rd(4, "R9"); rd(3, "R9");
        // R8 wipe with no pulse
        wr(2, 32'h4); rd(3, "R8"); rd(4, "R8"); rd(1, "R8");
        // R10 legacy keeps info after bank clear
        wr(6, 32'hFFFF_FFFF); rd(4, "R10");
        // R12 unmapped words
        wr(9, 32'hFFFF_FFFF); rd(9, "R12"); rd(63, "R12"); rd(0, "R12");

        // random traffic
        for (int i = 0; i < 4000; i++) begin
            logic [1:0] m;
            logic [NEP-1:0] e;
            e = '0;
            m = 2'(($urandom % 6 == 0) ? $urandom : 0);
            if ($urandom % 4 == 0) e = ep_bit(int'($urandom % NEP));
            if ($urandom % 16 == 0) e = e | ep_bit(int'($urandom % NEP));
            cyc(m, e, ($urandom % 3 == 0), int'($urandom % 11), $urandom, "");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule